// File: doc/BRIEF.md
# Serial Slave Converter Readout Port

This block is the digital output side of a 16-bit data converter when the host drives the serial clock. A behavioural converter stub reports the end of each conversion, and the block loads that result into a shift register. The result can be loaded in two's complement or in offset binary form. While the port is selected, the block presents the result on a serial data line, most significant bit first, and advances one bit on each active edge of the host clock.

A pin selects which host clock edge advances the data. A serial data input is shifted in behind the local word, so several converters can share one data line in a chain. A busy flag marks the span from conversion start until the new result is in the shift register. A one-cycle error pulse reports a read that was cut short by a new result.

The host clock is sampled in the system clock domain. It must toggle no faster than one quarter of the system clock rate.

Top module: `slaveReadoutPort`

## Requirements
- R1: `busy` is 1 in the cycle after a `convStart` strobe. It is 0 in the cycle after a `convDone` pulse, and in that same cycle the shift register already holds the new result.
- R2: While the port is enabled, `sdOut` shows the loaded result most significant bit first. Each active serial clock edge advances it by one bit, and 16 edges carry the whole word.
- R3: With `fmtOffset` = 0 the result is sent unchanged (two's complement). With `fmtOffset` = 1 bit 15 is inverted (offset binary). The choice is sampled when the result is loaded.
- R4: With `invClk` = 0, a rising `sclkIn` edge advances the data. A falling edge leaves `sdOut` unchanged, so the host samples on the falling edge.
- R5: With `invClk` = 1, a falling `sclkIn` edge advances the data. A rising edge leaves `sdOut` unchanged.
- R6: The level on `sdIn` at the k-th active edge of a read appears on `sdOut` after the (15+k)-th active edge, that is, 16 bit positions behind.
- R7: A `convDone` pulse that arrives after 1 to 15 bits of the current word have been shifted produces a `readErr` pulse of exactly one cycle, in the following cycle. The new result replaces the old one. A `convDone` after 0 bits, or after 16 or more bits, gives no pulse.
- R8: The port is enabled only while `csN` and `rdN` are both 0. When disabled, `sdOut` is 0 and `sdOe` is 0, and serial clock edges neither move the data nor count as read progress.
- R9: After reset, `busy`, `readErr`, `sdOut` and `sdOe` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| convStart | input | 1 | One-cycle strobe: conversion begins |
| convDone | input | 1 | One-cycle pulse from the converter stub: result valid |
| convResult | input | 16 | Conversion result, two's complement |
| fmtOffset | input | 1 | 1 selects offset binary coding, 0 selects two's complement |
| csN | input | 1 | Chip select, active low |
| rdN | input | 1 | Read enable, active low |
| sclkIn | input | 1 | Host serial clock, asynchronous |
| invClk | input | 1 | 0: rising edge advances data; 1: falling edge advances data |
| sdIn | input | 1 | Chain data input, shifted in behind the local word |
| sdOut | output | 1 | Serial data output, 0 while disabled |
| sdOe | output | 1 | Output enable for tristate modelling |
| busy | output | 1 | Conversion in progress |
| readErr | output | 1 | One-cycle pulse: unfinished read overrun by a new result |

## Verification
The assertions assume that `convStart` and `convDone` are single-cycle pulses and never arrive in the same cycle. They also assume that `csN` and `rdN` are synchronous to the system clock. The stimulus drives every control input at the falling system clock edge and pulses the conversion strobes on separate cycles. It holds each `sclkIn` level for four system cycles, so every edge passes the synchroniser cleanly. `sdIn` and `invClk` change only while `sclkIn` sits at its non-advancing level, or while the port is disabled.

// File: rtl/srpPkg.sv
package srpPkg;
  typedef struct packed {
    logic load;    // capture a new result
    logic shift;   // advance one bit
    logic enable;  // port selected
  } srpStrobe_t;
endpackage

// File: rtl/srpCtrl.sv
module srpCtrl
  import srpPkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       convStart,
  input  logic       convDone,
  input  logic       csN,
  input  logic       rdN,
  input  logic       sclkIn,
  input  logic       invClk,
  output srpStrobe_t strobe,
  output logic       busy,
  output logic       readErr
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

  logic [SYNC_STAGES-1:0] sclkPipe;
  logic                   sclkLast;
  logic                   sclkNow;
  logic                   riseEdge;
  logic                   fallEdge;
  logic                   activeEdge;
  logic                   portOn;
  logic [CNT_W-1:0]       bitCnt;
  logic                   midRead;

  // Synchroniser: the stage count is a parameter.
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rstN) sclkPipe <= '0;
        else       sclkPipe <= sclkIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rstN) sclkPipe <= '0;
        else       sclkPipe <= {sclkPipe[SYNC_STAGES-2:0], sclkIn};
      end
    end
  endgenerate

  assign sclkNow = sclkPipe[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) sclkLast <= 1'b0;
    else       sclkLast <= sclkNow;
  end

  assign riseEdge   = sclkNow & ~sclkLast;
  assign fallEdge   = ~sclkNow & sclkLast;
  assign activeEdge = invClk ? fallEdge : riseEdge;
  assign portOn     = ~csN & ~rdN;

  always_comb begin
    strobe.load   = convDone;
    strobe.shift  = activeEdge & portOn & ~convDone;
    strobe.enable = portOn;
  end

  // Read progress, saturating once the local word is out.
  always_ff @(posedge clk) begin
    if (!rstN)                             bitCnt <= '0;
    else if (strobe.load)                  bitCnt <= '0;
    else if (strobe.shift && bitCnt != FULL) bitCnt <= bitCnt + 1'b1;
  end

  assign midRead = (bitCnt != '0) && (bitCnt != FULL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      readErr <= 1'b0;
    end else begin
      readErr <= convDone & midRead;
      if (convDone)       busy <= 1'b0;
      else if (convStart) busy <= 1'b1;
    end
  end
endmodule

// File: rtl/srpData.sv
module srpData
  import srpPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  srpStrobe_t        strobe,
  input  logic [DATA_W-1:0] convResult,
  input  logic              fmtOffset,
  input  logic              sdIn,
  output logic              sdOut,
  output logic              sdOe
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] coded;

  // Offset binary: flip the sign bit of the two's complement value.
  assign coded = fmtOffset ? {~convResult[MSB], convResult[MSB-1:0]} : convResult;

  always_ff @(posedge clk) begin
    if (!rstN)             shiftReg <= '0;
    else if (strobe.load)  shiftReg <= coded;
    else if (strobe.shift) shiftReg <= {shiftReg[MSB-1:0], sdIn};
  end

  assign sdOut = strobe.enable & shiftReg[MSB];
  assign sdOe  = strobe.enable;
endmodule

// File: rtl/slaveReadoutPort.sv
module slaveReadoutPort
  import srpPkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              convStart,
  input  logic              convDone,
  input  logic [DATA_W-1:0] convResult,
  input  logic              fmtOffset,
  input  logic              csN,
  input  logic              rdN,
  input  logic              sclkIn,
  input  logic              invClk,
  input  logic              sdIn,
  output logic              sdOut,
  output logic              sdOe,
  output logic              busy,
  output logic              readErr
);
  srpStrobe_t strobe;

  srpCtrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .convStart(convStart), .convDone(convDone),
    .csN(csN), .rdN(rdN), .sclkIn(sclkIn), .invClk(invClk),
    .strobe(strobe), .busy(busy), .readErr(readErr)
  );

  srpData #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .convResult(convResult),
    .fmtOffset(fmtOffset), .sdIn(sdIn), .sdOut(sdOut), .sdOe(sdOe)
  );
endmodule

// File: rtl/srpChecker.sv
module srpChecker (
  input logic clk,
  input logic rstN,
  input logic convStart,
  input logic convDone,
  input logic csN,
  input logic rdN,
  input logic sdOut,
  input logic sdOe,
  input logic busy,
  input logic readErr
);
  AST_BUSY_SET: assert property (@(posedge clk) disable iff (!rstN)
    (convStart && !convDone) |=> busy); // R1
  AST_BUSY_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    convDone |=> !busy); // R1
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    readErr |=> !readErr); // R7
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    readErr |-> $past(convDone)); // R7
  AST_IDLE_LINE: assert property (@(posedge clk) disable iff (!rstN)
    (csN || rdN) |-> (!sdOe && !sdOut)); // R8
endmodule

bind slaveReadoutPort srpChecker u_chk (.*);

// File: tb/tb_slaveReadoutPort.sv
module tb_slaveReadoutPort;
  logic clk = 1'b0;
  logic rstN, convStart, convDone, fmtOffset, csN, rdN, sclkIn, invClk, sdIn;
  logic [15:0] convResult;
  logic sdOut, sdOe, busy, readErr;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  slaveReadoutPort dut (.*);

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Move sclk to the edge that advances data (adv=1) or the other one.
  task automatic sclkTo(input logic adv);
    sclkIn = invClk ? ~adv : adv;
    waitN(4);
  endtask

  task automatic setPort(input logic on, input logic inv);
    csN = ~on; rdN = ~on;
    if (!on) begin
      invClk = inv;
      sclkIn = invClk ? 1'b0 : 1'b1;  // rest at the advancing level
    end
    waitN(4);
  endtask

  task automatic convert(input logic [15:0] val, input logic fmt,
                         output logic errNow, output logic errNext);
    @(negedge clk); convStart = 1'b1;
    @(negedge clk); convStart = 1'b0;
    check("R1 busy rise", busy, 1'b1);
    waitN(3);
    convResult = val; fmtOffset = fmt; convDone = 1'b1;
    @(negedge clk); convDone = 1'b0;
    check("R1 busy fall", busy, 1'b0);
    errNow = readErr;
    @(negedge clk);
    errNext = readErr;
  endtask

  task automatic readBits(input int n, input logic [15:0] chain, output logic [31:0] got);
    got = '0;
    for (int k = 0; k < n; k++) begin
      sclkTo(1'b0);
      sdIn = (k < 16) ? chain[15-k] : 1'b0;
      got = {got[30:0], sdOut};
      sclkTo(1'b1);
    end
  endtask

  task automatic testReset();
    check("R9 busy", busy, 1'b0);
    check("R9 readErr", readErr, 1'b0);
    check("R9 sdOut", sdOut, 1'b0);
    check("R9 sdOe", sdOe, 1'b0);
  endtask

  task automatic testRiseShift();
    logic e0, e1; logic [31:0] w;
    setPort(1'b0, 1'b0);
    convert(16'h1234, 1'b0, e0, e1);
    setPort(1'b1, 1'b0);
    check("R8 sdOe on", sdOe, 1'b1);
    readBits(16, 16'h0, w);
    check("R2 R4 rising-edge word", w[15:0], 16'h1234);
    setPort(1'b0, 1'b0);
  endtask

  task automatic testFallShiftOffset();
    logic e0, e1; logic [31:0] w;
    setPort(1'b0, 1'b1);
    convert(16'h8001, 1'b1, e0, e1);
    setPort(1'b1, 1'b1);
    readBits(16, 16'h0, w);
    check("R3 R5 offset binary falling-edge", w[15:0], 16'h0001);
    setPort(1'b0, 1'b1);
    convert(16'h8001, 1'b0, e0, e1);
    setPort(1'b1, 1'b1);
    readBits(16, 16'h0, w);
    check("R3 two's complement", w[15:0], 16'h8001);
    setPort(1'b0, 1'b0);
  endtask

  task automatic testNonAdvEdge();
    logic e0, e1;
    setPort(1'b0, 1'b0);
    convert(16'h8000, 1'b0, e0, e1);
    setPort(1'b1, 1'b0);
    sclkTo(1'b0);  // falling edge with invClk=0
    check("R4 falling edge holds MSB", sdOut, 1'b1);
    setPort(1'b0, 1'b1);
    setPort(1'b1, 1'b1);
    sclkTo(1'b0);  // rising edge with invClk=1
    check("R5 rising edge holds MSB", sdOut, 1'b1);
    setPort(1'b0, 1'b0);
  endtask

  task automatic testDisabled();
    logic e0, e1; logic [31:0] w;
    setPort(1'b0, 1'b0);
    convert(16'hA5A5, 1'b0, e0, e1);
    check("R8 idle sdOut", sdOut, 1'b0);
    check("R8 idle sdOe", sdOe, 1'b0);
    for (int i = 0; i < 3; i++) begin
      sclkTo(1'b0); sclkTo(1'b1);
    end
    csN = 1'b0; waitN(2);
    check("R8 cs only sdOe", sdOe, 1'b0);
    csN = 1'b1;
    setPort(1'b1, 1'b0);
    readBits(16, 16'h0, w);
    check("R8 edges ignored while off", w[15:0], 16'hA5A5);
    setPort(1'b0, 1'b0);
  endtask

  task automatic testChain();
    logic e0, e1; logic [31:0] w;
    setPort(1'b0, 1'b0);
    convert(16'h00FF, 1'b0, e0, e1);
    setPort(1'b1, 1'b0);
    readBits(32, 16'hC3A5, w);
    check("R6 local word first", w[31:16], 16'h00FF);
    check("R6 chained word follows", w[15:0], 16'hC3A5);
    setPort(1'b0, 1'b0);
  endtask

  task automatic testReadErr();
    logic e0, e1; logic [31:0] w;
    setPort(1'b0, 1'b0);
    convert(16'h1111, 1'b0, e0, e1);
    check("R7 no pulse after 0 bits", {e0, e1}, 2'b00);
    setPort(1'b1, 1'b0);
    readBits(5, 16'h0, w);
    convert(16'h6C3E, 1'b0, e0, e1);
    check("R7 one-cycle pulse mid-read", {e0, e1}, 2'b10);
    readBits(16, 16'h0, w);
    check("R7 new result replaces old", w[15:0], 16'h6C3E);
    convert(16'h2222, 1'b0, e0, e1);
    check("R7 no pulse after full read", {e0, e1}, 2'b00);
    setPort(1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; convStart = 1'b0; convDone = 1'b0; convResult = '0;
    fmtOffset = 1'b0; csN = 1'b1; rdN = 1'b1; sclkIn = 1'b1; invClk = 1'b0; sdIn = 1'b0;
    waitN(4);
    rstN = 1'b1;
    waitN(1);
    testReset();
    testRiseShift();
    testFallShiftOffset();
    testNonAdvEdge();
    testDisabled();
    testChain();
    testReadErr();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule